// File: doc/BRIEF.md
# Interrupt Entry Stack Frame Sequencer

This block turns one interrupt or exception event into the ordered list of stack writes and flag changes needed to enter the handler. The caller has already decoded the gate and looked up any stack-switch values. It presents the old processor state on one cycle with `start_i`. The block then emits the frame one word at a time over a valid/ready handshake. Each word comes with its width and with the stack address it goes to. When the last word is accepted, the block pulses `done_o`. With that pulse it reports the flags the handler starts with, the effective vector, the handler target and whether the data segment registers must be nulled.

The block also keeps a nested-fault count. A fault that starts while an earlier fault is still undelivered is turned into a double fault. The third such fault produces a reset request instead of a frame. A delivery that completes clears the count. The environment cancels a delivery with `abort_i` when one of the stack writes itself faults.

Top module: `irq_frame_seq`

## Requirements
- R1: A push is 32 bits wide (`push_wide_o`=1) only in protected mode with `gate_type_i[1]`=1. Otherwise it is 16 bits wide and carries the low half of the value, zero-extended. Every word of one frame has the same width.
- R2: In protected mode with `v86_i`=1, the first four pushes are the GS, FS, DS and ES selectors, in that order, and `null_segs_o`=1 while `done_o` is high.
- R3: In protected mode, if `old_cpl_i` > `new_rpl_i` or `v86_i`=1, the old SS and then the old ESP are pushed next, and the stack starts from `new_esp_i`. Otherwise the stack starts from `old_esp_i`.
- R4: The old flags, the old CS and the old instruction pointer are then pushed, in that order. An error code, when pushed, comes last.
- R5: `err_code_i` is pushed only when `fault_i`=1, `pmode_i`=1 and the effective vector is 8, 10, 11, 12, 13, 14 or 17.
- R6: `new_flags_o` equals `old_flags_i` with bit 8 (trap) always cleared. Bit 9 (interrupt enable) is cleared in real mode or when `gate_type_i[0]`=0 (interrupt gate) and kept for trap gates. Bit 14 (nested task) is cleared in protected mode only.
- R7: `ivt_addr_o` = `ivt_base_i` + 4 × effective vector. In real mode the target offset is `ivt_entry_i[15:0]` and the target selector is `ivt_entry_i[31:16]`. In protected mode they come from `gate_off_i` (upper half zeroed for 16-bit gates) and `gate_sel_i`.
- R8: Each accepted start with `fault_i`=1 increments the fault count. If the count was already nonzero, the effective vector (`vec_o`) becomes 8.
- R9: A fault started while the count is 2 produces no push and no `done_o`. Instead, `reset_req_o` pulses for one cycle and the count returns to 0.
- R10: Acceptance of the final push clears the fault count.
- R11: Before each push the stack pointer drops by 2 or 4, according to the push width, and `push_addr_o` is the decremented value.
- R12: While `push_valid_o` is high and `push_ready_i` is low, the data and the address hold. `done_o` is a one-cycle pulse in the cycle after the final push is accepted. After reset no push is pending.
- R13: `abort_i` with a push pending ends the frame on the next cycle with no `done_o`, and the fault count is kept. Abort takes precedence over ready in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an entry; accepted when not busy |
| fault_i | input | 1 | Event is an exception (counts as a fault) |
| vec_i | input | 8 | Requested vector |
| pmode_i | input | 1 | Protected mode |
| v86_i | input | 1 | Entry from virtual-8086 mode |
| gate_type_i | input | 2 | bit1: 32-bit gate, bit0: trap gate |
| old_cpl_i | input | 2 | Current privilege level |
| new_rpl_i | input | 2 | Handler selector privilege |
| err_code_i | input | 32 | Error code value |
| old_flags_i | input | 32 | Flags before entry |
| old_cs_i | input | 16 | Old code selector |
| old_eip_i | input | 32 | Old instruction pointer |
| old_ss_i | input | 16 | Old stack selector |
| old_esp_i | input | 32 | Old stack pointer |
| new_esp_i | input | 32 | Stack pointer for the privilege switch |
| gs_i | input | 16 | GS selector |
| fs_i | input | 16 | FS selector |
| ds_i | input | 16 | DS selector |
| es_i | input | 16 | ES selector |
| gate_sel_i | input | 16 | Gate target selector |
| gate_off_i | input | 32 | Gate target offset |
| ivt_base_i | input | 32 | Vector table base |
| ivt_entry_i | input | 32 | Real-mode table entry read at `ivt_addr_o` |
| ivt_addr_o | output | 32 | Table address for the effective vector |
| push_ready_i | input | 1 | Stack write accepted |
| abort_i | input | 1 | Cancel the frame in progress |
| push_valid_o | output | 1 | Push word valid |
| push_data_o | output | 32 | Push word |
| push_wide_o | output | 1 | 1: 32-bit push, 0: 16-bit push |
| push_addr_o | output | 32 | Stack address of the push |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Delivery complete pulse |
| reset_req_o | output | 1 | Triple-fault reset request pulse |
| vec_o | output | 8 | Effective vector of the frame |
| new_flags_o | output | 32 | Handler entry flags |
| null_segs_o | output | 1 | Data segment registers become null |
| target_sel_o | output | 16 | Handler selector |
| target_off_o | output | 32 | Handler offset |

## Verification
The assertions check, on every cycle, the properties that do not depend on the frame's content. Data and address hold while a push is stalled. The stack address steps by exactly one word width between accepted pushes, and the width stays constant within a frame. The done and reset pulses last one cycle and never overlap a pending push, and an abort empties the stream. Which words make up a frame and in what order depends on the mode, the gate width, the privilege change and the error-code vector. The fault-count history across aborted and completed deliveries also matters. Only the bench's scenarios show those, by comparing every cycle against a queue-based model.

// File: rtl/irq_frame_seq.sv
module irq_frame_seq #(
  parameter logic [7:0] DF_VEC = 8'd8,
  parameter int RESET_COUNT = 3
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        fault_i,
  input  logic [7:0]  vec_i,
  input  logic        pmode_i,
  input  logic        v86_i,
  input  logic [1:0]  gate_type_i,
  input  logic [1:0]  old_cpl_i,
  input  logic [1:0]  new_rpl_i,
  input  logic [31:0] err_code_i,
  input  logic [31:0] old_flags_i,
  input  logic [15:0] old_cs_i,
  input  logic [31:0] old_eip_i,
  input  logic [15:0] old_ss_i,
  input  logic [31:0] old_esp_i,
  input  logic [31:0] new_esp_i,
  input  logic [15:0] gs_i,
  input  logic [15:0] fs_i,
  input  logic [15:0] ds_i,
  input  logic [15:0] es_i,
  input  logic [15:0] gate_sel_i,
  input  logic [31:0] gate_off_i,
  input  logic [31:0] ivt_base_i,
  input  logic [31:0] ivt_entry_i,
  output logic [31:0] ivt_addr_o,
  input  logic        push_ready_i,
  input  logic        abort_i,
  output logic        push_valid_o,
  output logic [31:0] push_data_o,
  output logic        push_wide_o,
  output logic [31:0] push_addr_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        reset_req_o,
  output logic [7:0]  vec_o,
  output logic [31:0] new_flags_o,
  output logic        null_segs_o,
  output logic [15:0] target_sel_o,
  output logic [31:0] target_off_o
);
  localparam int NSLOT = 10;
  localparam int IW = $clog2(NSLOT);
  localparam int CW = $clog2(RESET_COUNT + 1);
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int NT_BIT = 14;

  logic [NSLOT-1:0] pend_q, pend_nx, pend_n;
  logic [31:0]      slot_q [NSLOT];
  logic [31:0]      slot_n [NSLOT];
  logic [31:0]      sp_q;
  logic             wide_q;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    cur;

  wire go     = start_i && !push_valid_o;
  wire v86    = pmode_i && v86_i;
  wire esc    = fault_i && (cnt_q != '0);
  wire third  = fault_i && (cnt_q == CW'(RESET_COUNT - 1));
  wire [7:0] evec = esc ? DF_VEC : vec_i;
  wire wide_n = pmode_i && gate_type_i[1];
  wire priv   = pmode_i && ((old_cpl_i > new_rpl_i) || v86_i);
  wire errc   = fault_i && pmode_i &&
                (evec == 8'd8 || (evec >= 8'd10 && evec <= 8'd14) || evec == 8'd17);
  wire fire   = push_valid_o && push_ready_i && !abort_i;

  assign ivt_addr_o   = ivt_base_i + (32'(evec) << 2);
  assign push_valid_o = |pend_q;
  assign busy_o       = push_valid_o;
  assign push_addr_o  = sp_q - (wide_q ? 32'd4 : 32'd2);
  assign push_data_o  = wide_q ? slot_q[cur] : {16'h0, slot_q[cur][15:0]};
  assign push_wide_o  = wide_q;
  assign pend_nx      = pend_q & ~(NSLOT'(1) << cur);
  assign pend_n       = {errc, 3'b111, priv, priv, {4{v86}}};

  always_comb begin
    cur = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (pend_q[i]) cur = IW'(i);
  end

  always_comb begin
    slot_n[0] = 32'(gs_i);
    slot_n[1] = 32'(fs_i);
    slot_n[2] = 32'(ds_i);
    slot_n[3] = 32'(es_i);
    slot_n[4] = 32'(old_ss_i);
    slot_n[5] = old_esp_i;
    slot_n[6] = old_flags_i;
    slot_n[7] = 32'(old_cs_i);
    slot_n[8] = old_eip_i;
    slot_n[9] = err_code_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q       <= '0;
      sp_q         <= '0;
      wide_q       <= 1'b0;
      cnt_q        <= '0;
      done_o       <= 1'b0;
      reset_req_o  <= 1'b0;
      vec_o        <= '0;
      new_flags_o  <= '0;
      null_segs_o  <= 1'b0;
      target_sel_o <= '0;
      target_off_o <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else begin
      done_o      <= 1'b0;
      reset_req_o <= 1'b0;
      if (abort_i && push_valid_o) begin
        pend_q <= '0;
      end else if (fire) begin
        pend_q <= pend_nx;
        sp_q   <= push_addr_o;
        if (pend_nx == '0) begin
          done_o <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (go) begin
        if (third) begin
          reset_req_o <= 1'b1;
          cnt_q       <= '0;
        end else begin
          if (fault_i) cnt_q <= cnt_q + CW'(1);
          pend_q      <= pend_n;
          sp_q        <= priv ? new_esp_i : old_esp_i;
          wide_q      <= wide_n;
          vec_o       <= evec;
          null_segs_o <= v86;
          for (int i = 0; i < NSLOT; i++) slot_q[i] <= slot_n[i];
          new_flags_o <= old_flags_i
                         & ~(32'(1) << TF_BIT)
                         & ~((!pmode_i || !gate_type_i[0]) ? (32'(1) << IF_BIT) : 32'h0)
                         & ~(pmode_i ? (32'(1) << NT_BIT) : 32'h0);
          target_sel_o <= pmode_i ? gate_sel_i : ivt_entry_i[31:16];
          target_off_o <= pmode_i ? (wide_n ? gate_off_i : {16'h0, gate_off_i[15:0]})
                                  : {16'h0, ivt_entry_i[15:0]};
        end
      end
    end
  end
endmodule

// File: rtl/irq_frame_seq_chk.sv
module irq_frame_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        push_ready_i,
  input logic        abort_i,
  input logic        push_valid_o,
  input logic [31:0] push_data_o,
  input logic        push_wide_o,
  input logic [31:0] push_addr_o,
  input logic        done_o,
  input logic        reset_req_o,
  input logic [31:0] new_flags_o
);
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o && !push_ready_i && !abort_i |=>
      push_valid_o && $stable(push_data_o) && $stable(push_addr_o));

  a_r11_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o && push_ready_i && !abort_i |=>
      !push_valid_o ||
      (push_addr_o == $past(push_addr_o) - ($past(push_wide_o) ? 32'd4 : 32'd2)));

  a_r1_width_steady: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o && $past(push_valid_o) |-> $stable(push_wide_o));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !push_valid_o ##1 !done_o);

  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> !push_valid_o && !done_o);

  a_r13_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && push_valid_o |=> !push_valid_o && !done_o);

  a_r6_tf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !new_flags_o[8]);
endmodule

bind irq_frame_seq irq_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_ready_i(push_ready_i), .abort_i(abort_i),
  .push_valid_o(push_valid_o), .push_data_o(push_data_o), .push_wide_o(push_wide_o),
  .push_addr_o(push_addr_o), .done_o(done_o), .reset_req_o(reset_req_o),
  .new_flags_o(new_flags_o)
);

// File: tb/irq_frame_seq_bench.sv
module irq_frame_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, fault = 0, pm = 0, v86 = 0, ready = 0, abort = 0;
  logic [7:0]  vec = 0;
  logic [1:0]  gt = 0, ocpl = 0, nrpl = 0;
  logic [31:0] err = 32'hBEEF_0013, flags = 32'h0002_4302, eip = 32'h89AB_CDEF;
  logic [31:0] esp = 32'h0000_8000, nesp = 32'h0001_0000, goff = 32'hC0DE_1234;
  logic [31:0] ibase = 32'h0000_0400, ientry = 32'hF000_E987;
  logic [15:0] cs = 16'h1234, ss = 16'h0F0F, gs = 16'h1111, fs = 16'h2222;
  logic [15:0] ds = 16'h3333, es = 16'h4444, gsel = 16'h0008;
  logic [31:0] ivt_addr, pdata, paddr, nflags, toff;
  logic        pvalid, pwide, busy, done, rreq, nulls;
  logic [7:0]  vout;
  logic [15:0] tsel;

  int nchk = 0, nfail = 0, mcnt = 0;
  logic [31:0] qd[$], qa[$];
  logic        qw[$];

  always #5 clk = ~clk;

  irq_frame_seq u_irq_frame_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fault_i(fault), .vec_i(vec),
    .pmode_i(pm), .v86_i(v86), .gate_type_i(gt), .old_cpl_i(ocpl), .new_rpl_i(nrpl),
    .err_code_i(err), .old_flags_i(flags), .old_cs_i(cs), .old_eip_i(eip),
    .old_ss_i(ss), .old_esp_i(esp), .new_esp_i(nesp), .gs_i(gs), .fs_i(fs),
    .ds_i(ds), .es_i(es), .gate_sel_i(gsel), .gate_off_i(goff), .ivt_base_i(ibase),
    .ivt_entry_i(ientry), .ivt_addr_o(ivt_addr), .push_ready_i(ready), .abort_i(abort),
    .push_valid_o(pvalid), .push_data_o(pdata), .push_wide_o(pwide), .push_addr_o(paddr),
    .busy_o(busy), .done_o(done), .reset_req_o(rreq), .vec_o(vout),
    .new_flags_o(nflags), .null_segs_o(nulls), .target_sel_o(tsel), .target_off_o(toff));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // tag names the requirement this scenario targets; abort_at < 0 means run to completion
  task automatic deliver(input string tag, input logic f, input logic [7:0] v,
                         input logic p, input logic vm, input logic [1:0] g,
                         input logic [1:0] oc, input logic [1:0] nr, input int abort_at);
    logic [7:0]  evec;
    logic        third, wide, priv, errc, exp_done, aborted;
    logic [31:0] sp, ef, eoff;
    logic [15:0] esel;
    int k;
    @(negedge clk);
    fault = f; vec = v; pm = p; v86 = vm; gt = g; ocpl = oc; nrpl = nr;
    evec  = (f && mcnt != 0) ? 8'd8 : v;
    third = f && (mcnt == 2);
    wide  = p && g[1];
    priv  = p && ((oc > nr) || vm);
    errc  = f && p && (evec == 8 || (evec >= 10 && evec <= 14) || evec == 17);
    #1 chk({tag, " R7 table address"}, ivt_addr, ibase + 32'(evec) * 4);
    start = 1'b1;
    if (f) mcnt++;
    if (third) begin
      mcnt = 0;
      @(negedge clk); start = 1'b0;
      chk({tag, " R9 reset request"}, 32'(rreq), 1);
      chk({tag, " R9 no push"}, 32'(pvalid), 0);
      @(negedge clk);
      chk({tag, " R9 pulse ends"}, 32'(rreq), 0);
      return;
    end
    qd.delete(); qa.delete(); qw.delete();
    sp = priv ? nesp : esp;
    begin
      logic [31:0] vals[$];
      if (p && vm) vals = {vals, 32'(gs), 32'(fs), 32'(ds), 32'(es)};
      if (priv) vals = {vals, 32'(ss), esp};
      vals = {vals, flags, 32'(cs), eip};
      if (errc) vals.push_back(err);
      foreach (vals[i]) begin
        sp = sp - (wide ? 4 : 2);
        qd.push_back(wide ? vals[i] : (vals[i] & 32'h0000_FFFF));
        qa.push_back(sp);
        qw.push_back(wide);
      end
    end
    ef = flags & ~32'h100;
    if (!p || !g[0]) ef = ef & ~32'h200;
    if (p) ef = ef & ~32'h4000;
    esel = p ? gsel : ientry[31:16];
    eoff = p ? (wide ? goff : (goff & 32'hFFFF)) : (ientry & 32'hFFFF);
    exp_done = 0; aborted = 0; k = 0;
    forever begin
      @(negedge clk);
      start = 1'b0; ready = 1'b0; abort = 1'b0;
      if (exp_done) begin
        chk({tag, " R12 done pulse"}, 32'(done), 1);
        chk({tag, " R6 entry flags"}, nflags, ef);
        chk({tag, " R8 vector"}, 32'(vout), 32'(evec));
        chk({tag, " R2 null segments"}, 32'(nulls), 32'(p && vm));
        chk({tag, " R7 target selector"}, 32'(tsel), 32'(esel));
        chk({tag, " R7 target offset"}, toff, eoff);
        mcnt = 0;
        break;
      end
      if (aborted) begin
        chk({tag, " R13 abort clears valid"}, 32'(pvalid), 0);
        chk({tag, " R13 abort no done"}, 32'(done), 0);
        break;
      end
      chk({tag, " R12 valid"}, 32'(pvalid), 1);
      chk({tag, " R4/R5 push data"}, pdata, qd[0]);
      chk({tag, " R11 push address"}, paddr, qa[0]);
      chk({tag, " R1 push width"}, 32'(pwide), 32'(qw[0]));
      chk({tag, " R12 no early done"}, 32'(done), 0);
      if (k == abort_at) begin
        abort = 1'b1; ready = 1'b1; aborted = 1;
      end else begin
        ready = (k % 3) != 2;
        if (ready) begin
          void'(qd.pop_front()); void'(qa.pop_front()); void'(qw.pop_front());
          if (qd.size() == 0) exp_done = 1;
        end
      end
      k++;
    end
    @(negedge clk);
    chk({tag, " R12 idle after frame"}, 32'(pvalid | done), 0);
  endtask

  initial begin
    #2_000_000;
    nfail++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset valid", 32'(pvalid), 0);
    chk("R12 reset done", 32'(done), 0);
    chk("R9 reset request idle", 32'(rreq), 0);
    rst_n = 1'b1;
    deliver("real-mode int R7 R1 R6", 0, 8'h21, 0, 0, 2'b10, 0, 0, -1);
    deliver("real-mode fault R5", 1, 8'd13, 0, 0, 2'b10, 0, 0, -1);
    deliver("pm 32-bit same-level R4", 0, 8'h80, 1, 0, 2'b10, 0, 0, -1);
    deliver("pm trap privilege change R3 R5 R6", 1, 8'd14, 1, 0, 2'b11, 3, 0, -1);
    deliver("pm 16-bit from v86 R2 R3", 1, 8'd13, 1, 1, 2'b00, 3, 0, -1);
    deliver("pm fault without code R5", 1, 8'd6, 1, 0, 2'b10, 0, 0, -1);
    deliver("first fault aborted R13", 1, 8'd13, 1, 0, 2'b10, 0, 0, 1);
    deliver("second fault escalates R8", 1, 8'd0, 1, 0, 2'b10, 0, 0, 2);
    deliver("third fault resets R9", 1, 8'd5, 1, 0, 2'b10, 0, 0, -1);
    deliver("after reset count cleared R9", 1, 8'd0, 1, 0, 2'b10, 0, 0, 0);
    deliver("pending count escalates R8", 1, 8'd13, 1, 0, 2'b10, 0, 0, -1);
    deliver("delivery cleared count R10", 1, 8'd0, 1, 0, 2'b11, 0, 0, -1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule